// File: doc/BRIEF.md
# Pipelined Conversion Sequencer

This block is the digital control model of a sampling converter whose results pass through a three-stage pipeline. Each rising edge of `start_i` opens a conversion cycle and captures the `sample_i` word. `busy_o` is high for a fixed number of clock cycles after that edge. The pipeline advances once per start edge, not once per clock cycle. Because of this, the word captured at start k appears on `data_o` when start k+3 arrives, and it then stays there until the next start edge.

The block measures the start timing in system-clock cycles. It checks the width of each high pulse against two legal windows. A slow-rate exception allows wide pulses when the converter is not running at full rate. It also checks the low time that comes before each start. Any violation sets the width-error tag of the sample it affects.

A start edge that arrives while a conversion is still busy begins a new conversion. Both the interrupted result and the new result are then tagged invalid. The tags travel through the pipeline together with the data, so the invalid and width-error flags always describe the word currently shown on `data_o`.

Top module: `conv_sequencer`

## Requirements
- R1: Only a rising edge of `start_i` starts a conversion. Holding `start_i` high does not retrigger `busy_o` and does not advance the pipeline. Changes on `sample_i` after the edge are ignored.
- R2: `busy_o` goes high in the cycle after a start edge and stays high for exactly CONV_CYCLES clock cycles (default 30). It is low otherwise.
- R3: At the k-th start edge with k of 4 or more, `data_o` takes the sample captured at start k-3 and `valid_o` is 1. Before the 4th start edge, `valid_o` is 0 and `data_o` is 0.
- R4: `data_o`, `valid_o`, `invalid_o` and `width_err_o` change only in the cycle after a start edge.
- R5: A start edge that arrives while `busy_o` is high sets `invalid_o` for the result of the conversion it interrupts and for its own result. Every other result has `invalid_o` equal to 0.
- R6: A high pulse on `start_i` lasting 3..7 or 25..38 clock cycles is legal. Any other width sets `width_err_o` for that pulse's sample.
- R7: If the interval from the previous start edge to this one exceeds FULL_PERIOD cycles (default 42), any high width of 3 cycles or more is legal. The first start after reset counts as such a slow start.
- R8: If `start_i` was low for fewer than 3 cycles before a start edge (not counting the first start after reset), `width_err_o` is set for that edge's sample.
- R9: While `rst_ni` is low, `busy_o`, `data_o`, `valid_o`, `invalid_o` and `width_err_o` are all 0.
- R10: Once `valid_o` is 1, it stays 1 until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start-convert pulse; the rising edge is active |
| sample_i | input | DATA_W | Sample word, captured on the start edge |
| busy_o | output | 1 | Conversion in progress |
| data_o | output | DATA_W | Result word, three conversions late |
| valid_o | output | 1 | Pipeline filled; `data_o` holds a real result |
| invalid_o | output | 1 | Result was hit by a mid-conversion restart |
| width_err_o | output | 1 | Start pulse high or low time out of range for this result |

## Verification
The directed pulses come first. Steady full-rate pulses fill the pipeline and show the three-start latency. A short period checks that both the interrupted result and the restarting result are flagged, while their neighbours stay clean. Widths just inside and just outside each window, a wide pulse after a full-rate period and the same width after a slow period, and one- and two-cycle low gaps tell the two width rules apart from the low-time rule. Random high and low times over a wide range then mix all of these conditions. Holding `start_i` high past the end of the conversion checks that a level does not retrigger. Changing `sample_i` after each edge checks that data is captured only on the edge.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;
  typedef struct packed {
    logic vld;
    logic inv;
    logic werr;
  } tag_t;
endpackage

// File: rtl/conv_edge_timer.sv
module conv_edge_timer #(
  parameter int CNT_W       = 8,
  parameter int W1_MIN      = 3,
  parameter int W1_MAX      = 7,
  parameter int W2_MIN      = 25,
  parameter int W2_MAX      = 38,
  parameter int LOW_MIN     = 3,
  parameter int FULL_PERIOD = 42
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic rise_o,
  output logic fall_o,
  output logic low_bad_o,
  output logic width_bad_o
);
  localparam logic [CNT_W-1:0] CMAX  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] A1    = CNT_W'(W1_MIN);
  localparam logic [CNT_W-1:0] B1    = CNT_W'(W1_MAX);
  localparam logic [CNT_W-1:0] A2    = CNT_W'(W2_MIN);
  localparam logic [CNT_W-1:0] B2    = CNT_W'(W2_MAX);
  localparam logic [CNT_W-1:0] LMIN  = CNT_W'(LOW_MIN);
  localparam logic [CNT_W-1:0] FPER  = CNT_W'(FULL_PERIOD);

  logic             start_q, slow_q;
  logic [CNT_W-1:0] hi_cnt, lo_cnt, per_cnt;
  logic             in_w1, in_w2, slow_ok;

  assign rise_o = start_i & ~start_q;
  assign fall_o = ~start_i & start_q;

  // hi_cnt holds the sampled high width at the falling edge
  assign in_w1       = (hi_cnt >= A1) && (hi_cnt <= B1);
  assign in_w2       = (hi_cnt >= A2) && (hi_cnt <= B2);
  assign slow_ok     = slow_q && (hi_cnt >= A1);
  assign width_bad_o = ~(in_w1 | in_w2 | slow_ok);
  assign low_bad_o   = lo_cnt < LMIN;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= 1'b0;
      slow_q  <= 1'b1;
      hi_cnt  <= '0;
      lo_cnt  <= CMAX;
      per_cnt <= CMAX;
    end else begin
      start_q <= start_i;
      if (rise_o) begin
        hi_cnt  <= CNT_W'(1);
        per_cnt <= CNT_W'(1);
        slow_q  <= per_cnt > FPER;
      end else begin
        if (per_cnt != CMAX) per_cnt <= per_cnt + 1'b1;
        if (start_i && start_q && hi_cnt != CMAX) hi_cnt <= hi_cnt + 1'b1;
      end
      if (fall_o) lo_cnt <= CNT_W'(1);
      else if (!start_i && !start_q && lo_cnt != CMAX) lo_cnt <= lo_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/conv_busy_ctrl.sv
module conv_busy_ctrl #(
  parameter int CONV_CYCLES = 30
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rise_i,
  output logic busy_o,
  output logic restart_o
);
  localparam int BW = $clog2(CONV_CYCLES + 1);
  localparam logic [BW-1:0] LOAD = BW'(CONV_CYCLES);

  logic [BW-1:0] left_q;

  assign busy_o    = left_q != '0;
  assign restart_o = rise_i & busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            left_q <= '0;
    else if (rise_i)        left_q <= LOAD;
    else if (left_q != '0)  left_q <= left_q - 1'b1;
  end
endmodule

// File: rtl/conv_pipe.sv
module conv_pipe
  import conv_seq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              restart_i,
  input  logic              low_bad_i,
  input  logic              width_bad_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              invalid_o,
  output logic              width_err_o
);
  logic [DATA_W-1:0] out_dat_q;
  tag_t              out_tag_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_st
    logic [DATA_W-1:0] dat_q;
    tag_t              tag_q;
    if (i == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          dat_q <= '0;
          tag_q <= '0;
        end else if (rise_i) begin
          dat_q <= sample_i;
          tag_q <= '{vld: 1'b1, inv: restart_i, werr: low_bad_i};
        end else if (fall_i && width_bad_i) begin
          tag_q.werr <= 1'b1;
        end
      end
    end else begin : g_body
      // only the stage just behind the head holds the interrupted result
      localparam bit HIT = (i == 1);
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          dat_q <= '0;
          tag_q <= '0;
        end else if (rise_i) begin
          dat_q <= g_st[i-1].dat_q;
          tag_q <= '{vld:  g_st[i-1].tag_q.vld,
                     inv:  g_st[i-1].tag_q.inv | (HIT & restart_i),
                     werr: g_st[i-1].tag_q.werr};
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_dat_q <= '0;
      out_tag_q <= '0;
    end else if (rise_i) begin
      out_dat_q <= g_st[DEPTH-1].dat_q;
      out_tag_q <= g_st[DEPTH-1].tag_q;
    end
  end

  assign data_o      = out_dat_q;
  assign valid_o     = out_tag_q.vld;
  assign invalid_o   = out_tag_q.inv;
  assign width_err_o = out_tag_q.werr;
endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer #(
  parameter int DATA_W      = 16,
  parameter int PIPE_DEPTH  = 3,
  parameter int CONV_CYCLES = 30,
  parameter int CNT_W       = 8,
  parameter int W1_MIN      = 3,
  parameter int W1_MAX      = 7,
  parameter int W2_MIN      = 25,
  parameter int W2_MAX      = 38,
  parameter int LOW_MIN     = 3,
  parameter int FULL_PERIOD = 42
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic              busy_o,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              invalid_o,
  output logic              width_err_o
);
  logic rise, fall, low_bad, width_bad, restart;

  conv_edge_timer #(
    .CNT_W(CNT_W), .W1_MIN(W1_MIN), .W1_MAX(W1_MAX), .W2_MIN(W2_MIN),
    .W2_MAX(W2_MAX), .LOW_MIN(LOW_MIN), .FULL_PERIOD(FULL_PERIOD)
  ) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .rise_o(rise), .fall_o(fall), .low_bad_o(low_bad), .width_bad_o(width_bad)
  );

  conv_busy_ctrl #(.CONV_CYCLES(CONV_CYCLES)) u_busy (
    .clk_i(clk_i), .rst_ni(rst_ni), .rise_i(rise),
    .busy_o(busy_o), .restart_o(restart)
  );

  conv_pipe #(.DATA_W(DATA_W), .DEPTH(PIPE_DEPTH)) u_pipe (
    .clk_i(clk_i), .rst_ni(rst_ni), .rise_i(rise), .fall_i(fall),
    .restart_i(restart), .low_bad_i(low_bad), .width_bad_i(width_bad),
    .sample_i(sample_i), .data_o(data_o), .valid_o(valid_o),
    .invalid_o(invalid_o), .width_err_o(width_err_o)
  );
endmodule

// File: rtl/conv_sequencer_chk.sv
module conv_sequencer_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              busy_o,
  input logic [DATA_W-1:0] data_o,
  input logic              valid_o,
  input logic              invalid_o,
  input logic              width_err_o
);
  AST_BUSY_ON_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(start_i) |=> busy_o); // R2

  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$rose(start_i) |=> ($stable(data_o) && $stable(valid_o)
                         && $stable(invalid_o) && $stable(width_err_o))); // R4

  AST_VALID_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> valid_o); // R10

  AST_FLAGS_NEED_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (invalid_o || width_err_o) |-> valid_o); // R5
endmodule

bind conv_sequencer conv_sequencer_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .busy_o(busy_o),
  .data_o(data_o), .valid_o(valid_o), .invalid_o(invalid_o),
  .width_err_o(width_err_o)
);

// File: tb/conv_sequencer_bench.sv
module conv_sequencer_bench;
  localparam int DW = 16, CONV = 30, LOWMIN = 3, FULL = 42;

  logic          clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [DW-1:0] sample = '0;
  logic          busy, valid, inval, werr;
  logic [DW-1:0] data;

  conv_sequencer u_conv_sequencer (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .sample_i(sample),
    .busy_o(busy), .data_o(data), .valid_o(valid), .invalid_o(inval),
    .width_err_o(werr)
  );

  always #4 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  logic [DW-1:0] e_dat [0:1023];
  bit e_inv [0:1023];
  bit e_werr [0:1023];
  int k = 0, since = 1000, prev_hi = 0, prev_lo = 0;
  logic [DW-1:0] x_dat = '0;
  bit x_vld = 0, x_inv = 0, x_werr = 0;

  function automatic bit width_ok(int hi, bit slow);
    return (hi >= 3 && hi <= 7) || (hi >= 25 && hi <= 38) || (slow && hi >= 3);
  endfunction

  task automatic chk(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual %0h expected %0h (start %0d)", req, act, exp, k);
    end
  endtask

  task automatic observe();
    chk("R1 R2 busy", busy, (since <= CONV));
    chk("R3 R4 data", data, x_dat);
    chk("R3 R10 valid", valid, x_vld);
    chk("R5 invalid", inval, x_inv);
    chk("R6 R7 R8 width flag", werr, x_werr);
  endtask

  task automatic pulse(int hi, int lo, logic [DW-1:0] smp);
    bit slow, rs;
    int per;
    k++;
    per  = prev_hi + prev_lo;
    slow = (k == 1) || (per > FULL);
    rs   = (k > 1) && (per <= CONV);
    e_dat[k]  = smp;
    e_inv[k]  = rs;
    if (rs) e_inv[k-1] = 1;
    e_werr[k] = ((k > 1) && (prev_lo < LOWMIN)) || !width_ok(hi, slow);
    start  = 1'b1;
    sample = smp;
    for (int c = 0; c < hi + lo; c++) begin
      if (c == hi) start = 1'b0;
      @(posedge clk);
      if (c == 0) begin
        since = 1;
        if (k >= 4) begin
          x_dat = e_dat[k-3]; x_vld = 1; x_inv = e_inv[k-3]; x_werr = e_werr[k-3];
        end
      end else since++;
      @(negedge clk);
      observe();
      sample = DW'($urandom); // R1: ignored after the edge
    end
    prev_hi = hi;
    prev_lo = lo;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9 reset state
    chk("R9 busy", busy, 0);
    chk("R9 data", data, 0);
    chk("R9 valid", valid, 0);
    chk("R9 invalid", inval, 0);
    chk("R9 width flag", werr, 0);
    rst_n = 1'b1;
    @(negedge clk);
    pulse(6, 36, 16'h1111);
    pulse(6, 36, 16'h2222);
    pulse(6, 36, 16'h3333);
    pulse(6, 36, 16'h4444);   // R3 first valid output
    pulse(5, 10, 16'h5555);
    pulse(6, 36, 16'h6666);   // R5 restart hits 5555 and 6666
    pulse(10, 32, 16'h7777);  // R6 outside both windows
    pulse(30, 12, 16'h8888);  // R6 second window
    pulse(50, 20, 16'h9999);  // R6 wide at full rate
    pulse(50, 20, 16'haaaa);  // R7 wide after slow period
    pulse(6, 2, 16'hbbbb);
    pulse(6, 36, 16'hcccc);   // R8 short low time before
    pulse(1, 41, 16'hdddd);
    pulse(38, 4, 16'heeee);
    pulse(39, 3, 16'hf0f0);
    pulse(7, 1, 16'h0f0f);
    pulse(3, 39, 16'h1234);   // R8 and R5 together
    pulse(25, 17, 16'h4321);
    for (int i = 0; i < 250; i++)
      pulse(1 + int'($urandom % 45), 1 + int'($urandom % 50), DW'($urandom));
    repeat (3) pulse(6, 36, DW'($urandom));
    finish_run();
  end
endmodule